// File: doc/BRIEF.md
# Read Reorder Demultiplexer

This block sits between a single bus master and a small set of targets on a request/wait bus whose reads are pipelined. It picks a target from the upper address bits, forwards the request and its write data to that target alone, and returns the chosen target's wait signal to the master. Reads are split into two phases: the request is accepted in one cycle and the reply arrives some cycles later.

Targets answer reads with their own latencies, which can vary. Replies from different targets can therefore arrive in the wrong order, or several in the same cycle. The block keeps a queue of target indices, one entry per accepted read, and a small FIFO per target for replies that arrive before their turn. The master sees replies strictly in the order its reads were accepted, one per cycle. A reply that comes in from the expected target while nothing is parked for it goes straight through in the same cycle.

Top module: `rd_reorder_demux`

## Requirements
- R1: The target index is the two-bit field at address bits 29:28. A field value of NT or more selects target NT-1. With the default NT=3, the field values 0, 1 and 2 select targets 0, 1 and 2, and the value 3 selects target 2.
- R2: While the master requests and the request is not blocked, exactly the selected target sees its request bit high. All other targets see it low, and none sees it high while the master is idle. Address, write enable, write data and byte mask are passed through unchanged.
- R3: For an unblocked request, the wait returned to the master equals the selected target's wait. It is low while the master is idle.
- R4: When QDEPTH reads are outstanding, a new read is held with the master's wait high and no target request. Writes are not held by this condition.
- R5: Read data reaches the master in the order the reads were accepted.
- R6: If the expected target's reply arrives while nothing is parked for that target, it appears at the master in that same cycle with its data unchanged.
- R7: A reply that arrives while an earlier read is still unanswered is parked and delivered later. Replies that arrive together are delivered one per cycle. The master's valid is high for exactly one cycle per read.
- R8: Writes add no entry to the order queue and never cause a reply at the master.
- R9: After reset, no reads are outstanding, the master's valid is low and no target request is high.
- R10: With the order queue filled to QDEPTH, every accepted read is delivered exactly once with correct data. The queue and the parking FIFOs are never pushed when full nor popped when empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master transfer request |
| m_addr | input | 32 | Master address |
| m_wren | input | 1 | Master write enable (low = read) |
| m_wdata | input | 32 | Master write data |
| m_wmask | input | 4 | Master byte write mask |
| m_wait | output | 1 | Wait returned to master |
| m_rvalid | output | 1 | Read reply valid to master |
| m_rdata | output | 32 | Read reply data to master |
| t_req | output | NT | Per-target transfer request |
| t_addr | output | 32 | Address to targets |
| t_wren | output | 1 | Write enable to targets |
| t_wdata | output | 32 | Write data to targets |
| t_wmask | output | 4 | Byte mask to targets |
| t_wait | input | NT | Per-target wait |
| t_rvalid | input | NT | Per-target reply valid |
| t_rdata | input | NT*32 | Per-target reply data, target i in bits i*32 +: 32 |

## Verification
A wrong head in the order queue shows at the master in the first cycle in which that read should be answered: the wrong data is presented or valid stays low. A lost or doubled entry in a parking FIFO shows as a missing, repeated or reordered tag at the master, at the latest when that target's next reply falls due. A wrong occupancy count shows in the cycle the queue should fill, because the master's wait no longer rises or falls on the right read. Every target reply carries a unique tag, so the reference model can point to the exact reply that went astray.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

  // Clamp a raw address field to a legal target index.
  function automatic int unsigned pick_target(input int unsigned field, input int unsigned nt);
    return (field >= nt) ? nt - 1 : field;
  endfunction

  // Circular pointer advance for a FIFO of the given depth.
  function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/rdx_fifo.sv
module rdx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  import rdx_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= PW'(ring_next(int'(wp), DEPTH));
      if (do_pop)  rp <= PW'(ring_next(int'(rp), DEPTH));
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rdx_sel.sv
module rdx_sel #(
  parameter int NT = 3,
  parameter int IW = 2
) (
  input  logic [IW-1:0] field,
  output logic [IW-1:0] sel
);
  import rdx_pkg::*;
  assign sel = IW'(pick_target(int'(field), NT));
endmodule

// File: rtl/rd_reorder_demux.sv
module rd_reorder_demux #(
  parameter int NT      = 3,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int MW      = 4,
  parameter int SEL_LSB = 28,
  parameter int QDEPTH  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_req,
  input  logic [AW-1:0]    m_addr,
  input  logic             m_wren,
  input  logic [DW-1:0]    m_wdata,
  input  logic [MW-1:0]    m_wmask,
  output logic             m_wait,
  output logic             m_rvalid,
  output logic [DW-1:0]    m_rdata,
  output logic [NT-1:0]    t_req,
  output logic [AW-1:0]    t_addr,
  output logic             t_wren,
  output logic [DW-1:0]    t_wdata,
  output logic [MW-1:0]    t_wmask,
  input  logic [NT-1:0]    t_wait,
  input  logic [NT-1:0]    t_rvalid,
  input  logic [NT*DW-1:0] t_rdata
);
  localparam int IW = $clog2(NT);
  localparam int NP = 1 << IW;

  // Named internal events, observed by the bound checker.
  logic [IW-1:0] sel, head;
  logic          blocked, fwd, accept;
  logic          oq_push, oq_pop, oq_full, oq_empty;
  logic          bypass, from_hold;
  logic [NP-1:0] wait_pad, rv_pad;
  logic [NP-1:0] hold_push, hold_pop, hold_full, hold_empty;
  logic [DW-1:0] hold_rdata [NP];
  logic [DW-1:0] rd_pad     [NP];

  rdx_sel #(.NT(NT), .IW(IW)) u_sel (
    .field (m_addr[SEL_LSB +: IW]),
    .sel   (sel)
  );

  // Request forwarding
  assign t_addr   = m_addr;
  assign t_wren   = m_wren;
  assign t_wdata  = m_wdata;
  assign t_wmask  = m_wmask;
  assign wait_pad = NP'(t_wait);
  assign rv_pad   = NP'(t_rvalid);
  assign blocked  = m_req & ~m_wren & oq_full;
  assign fwd      = m_req & ~blocked;
  assign m_wait   = m_req & (blocked | wait_pad[sel]);
  assign accept   = m_req & ~m_wait;
  assign oq_push  = accept & ~m_wren;

  for (genvar i = 0; i < NT; i++) begin : g_req
    assign t_req[i] = fwd & (sel == IW'(i));
  end

  // Issue-order queue of target indices
  rdx_fifo #(.W(IW), .DEPTH(QDEPTH)) u_order (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (oq_push),
    .wdata (sel),
    .pop   (oq_pop),
    .rdata (head),
    .empty (oq_empty),
    .full  (oq_full)
  );

  // Reply selection: parked data first, else direct bypass
  assign from_hold = ~oq_empty & ~hold_empty[head];
  assign bypass    = ~oq_empty &  hold_empty[head] & rv_pad[head];
  assign oq_pop    = from_hold | bypass;
  assign m_rvalid  = oq_pop;
  assign m_rdata   = from_hold ? hold_rdata[head] : rd_pad[head];

  // Per-target parking FIFOs
  for (genvar i = 0; i < NP; i++) begin : g_hold
    if (i < NT) begin : g_real
      assign rd_pad[i]    = t_rdata[i*DW +: DW];
      assign hold_push[i] = rv_pad[i] & ~(bypass & (head == IW'(i)));
      assign hold_pop[i]  = from_hold & (head == IW'(i));
      rdx_fifo #(.W(DW), .DEPTH(QDEPTH)) u_park (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (hold_push[i]),
        .wdata (rd_pad[i]),
        .pop   (hold_pop[i]),
        .rdata (hold_rdata[i]),
        .empty (hold_empty[i]),
        .full  (hold_full[i])
      );
    end else begin : g_pad
      assign rd_pad[i]     = '0;
      assign hold_push[i]  = 1'b0;
      assign hold_pop[i]   = 1'b0;
      assign hold_rdata[i] = '0;
      assign hold_empty[i] = 1'b1;
      assign hold_full[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/rdx_checker.sv
module rdx_checker #(
  parameter int NT = 3,
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_req,
  input logic          m_wren,
  input logic          m_wait,
  input logic          m_rvalid,
  input logic [NT-1:0] t_req,
  input logic          oq_push,
  input logic          oq_pop,
  input logic          oq_full,
  input logic          oq_empty,
  input logic          bypass,
  input logic          from_hold,
  input logic [NP-1:0] hold_push,
  input logic [NP-1:0] hold_pop,
  input logic [NP-1:0] hold_full,
  input logic [NP-1:0] hold_empty
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(t_req)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !m_req |-> (t_req == '0)); // R2
  AST_FULL_HOLDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_wren && oq_full) |-> (m_wait && t_req == '0)); // R4
  AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bypass && from_hold)); // R7
  AST_VALID_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> !oq_empty); // R8
  AST_PUSH_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (oq_push && !oq_pop) |=> !oq_empty); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    oq_push |-> !oq_full); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    oq_pop |-> !oq_empty); // R10
  AST_PARK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_push & hold_full) == '0); // R10
  AST_PARK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_pop & hold_empty) == '0); // R10
endmodule

bind rd_reorder_demux rdx_checker #(.NT(NT), .NP(NP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .m_req      (m_req),
  .m_wren     (m_wren),
  .m_wait     (m_wait),
  .m_rvalid   (m_rvalid),
  .t_req      (t_req),
  .oq_push    (oq_push),
  .oq_pop     (oq_pop),
  .oq_full    (oq_full),
  .oq_empty   (oq_empty),
  .bypass     (bypass),
  .from_hold  (from_hold),
  .hold_push  (hold_push),
  .hold_pop   (hold_pop),
  .hold_full  (hold_full),
  .hold_empty (hold_empty)
);

// File: tb/rd_reorder_demux_bench.sv
module rd_reorder_demux_bench;
  localparam int NT = 3;
  localparam int QD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             m_req = 1'b0, m_wren = 1'b0;
  logic [31:0]      m_addr = '0, m_wdata = '0;
  logic [3:0]       m_wmask = '0;
  logic             m_wait, m_rvalid;
  logic [31:0]      m_rdata;
  logic [NT-1:0]    t_req, t_wait, t_rvalid = '0;
  logic [31:0]      t_addr, t_wdata;
  logic             t_wren;
  logic [3:0]       t_wmask;
  logic [NT*32-1:0] t_rdata = '0;
  logic [NT-1:0]    stall = '0;

  assign t_wait = t_req & stall;

  rd_reorder_demux u_rd_reorder_demux (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_addr(m_addr), .m_wren(m_wren),
    .m_wdata(m_wdata), .m_wmask(m_wmask), .m_wait(m_wait), .m_rvalid(m_rvalid),
    .m_rdata(m_rdata), .t_req(t_req), .t_addr(t_addr), .t_wren(t_wren),
    .t_wdata(t_wdata), .t_wmask(t_wmask), .t_wait(t_wait), .t_rvalid(t_rvalid),
    .t_rdata(t_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  // Behavioural reference state
  int unsigned ord_q [$];
  logic [31:0] issue_q [$];
  logic [31:0] park [NT][$];
  logic [31:0] tq_d [NT][$];
  int          tq_t [NT][$];
  int          lat [NT];
  int          lat_var = 0;
  bit          rand_stall = 0;
  int          cyc = 0, delivered = 0, bypass_hits = 0, parked = 0, max_simul = 0;
  logic [31:0] tag_next = 32'hA000_0000;

  int          sel_e, h;
  bit          blk, ev, hsrc, exp_wait, acc_rd;
  logic [NT-1:0] exp_treq;
  logic [31:0] ed;

  // Reference model, compared at every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      sel_e = int'((m_addr >> 28) & 32'd3);
      if (sel_e >= NT) sel_e = NT - 1;
      blk = m_req && !m_wren && (ord_q.size() == QD);
      exp_treq = (m_req && !blk) ? NT'(1 << sel_e) : '0;
      chk(t_req == exp_treq, "R2 target request", 64'(t_req), 64'(exp_treq));
      if (m_req)
        chk(t_addr == m_addr && t_wdata == m_wdata && t_wren == m_wren && t_wmask == m_wmask,
            "R2 forwarded fields", 64'(t_addr), 64'(m_addr));
      exp_wait = m_req && (blk || stall[sel_e]);
      chk(m_wait == exp_wait, "R3 master wait", 64'(m_wait), 64'(exp_wait));

      ev = 0; hsrc = 0; ed = '0; h = 0;
      if (ord_q.size() > 0) begin
        h = int'(ord_q[0]);
        if (park[h].size() > 0) begin ev = 1; hsrc = 1; ed = park[h][0]; end
        else if (t_rvalid[h]) begin ev = 1; ed = t_rdata[h*32 +: 32]; end
      end
      chk(m_rvalid == ev, "R7 delivery cycle", 64'(m_rvalid), 64'(ev));
      if (ev && m_rvalid) chk(m_rdata == ed, "R6 delivered data", 64'(m_rdata), 64'(ed));
      if (m_rvalid) begin
        if (issue_q.size() == 0) chk(1'b0, "R8 reply with no read pending", 64'(m_rdata), 64'(0));
        else begin
          chk(m_rdata == issue_q[0], "R5 issue order", 64'(m_rdata), 64'(issue_q[0]));
          void'(issue_q.pop_front());
          delivered++;
        end
      end
      if (ev && !hsrc) bypass_hits++;
      if ($countones(t_rvalid) > max_simul) max_simul = $countones(t_rvalid);

      if (ev) begin
        if (hsrc) void'(park[h].pop_front());
        void'(ord_q.pop_front());
      end
      for (int i = 0; i < NT; i++)
        if (t_rvalid[i] && !(ev && !hsrc && i == h)) begin
          park[i].push_back(t_rdata[i*32 +: 32]);
          parked++;
        end

      acc_rd = m_req && !exp_wait && !m_wren;
      if (acc_rd) begin
        ord_q.push_back(sel_e);
        issue_q.push_back(tag_next);
      end
      for (int i = 0; i < NT; i++)
        if (t_req[i] && !t_wait[i] && !t_wren) begin
          tq_d[i].push_back(tag_next);
          tq_t[i].push_back(cyc + lat[i] + ((lat_var > 0) ? int'($urandom % lat_var) : 0));
        end
      if (acc_rd || (t_req != '0 && !t_wren)) tag_next++;
    end
    cyc++;
  end

  // Target models: in-order replies per target, driven after the rising edge
  always @(posedge clk) begin
    #1;
    for (int i = 0; i < NT; i++) begin
      if (tq_t[i].size() > 0 && tq_t[i][0] <= cyc) begin
        t_rvalid[i] = 1'b1;
        t_rdata[i*32 +: 32] = tq_d[i][0];
        void'(tq_t[i].pop_front());
        void'(tq_d[i].pop_front());
      end else begin
        t_rvalid[i] = 1'b0;
      end
    end
    if (rand_stall) stall = NT'($urandom % 8) & NT'($urandom % 8);
  end

  task automatic xfer(input int field, input bit wr);
    m_req   = 1'b1;
    m_wren  = wr;
    m_addr  = {2'b00, 2'(field), 28'($urandom)};
    m_wdata = $urandom;
    m_wmask = 4'($urandom);
    do @(negedge clk); while (m_wait);
    @(posedge clk); #1;
    m_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  int d0;

  initial begin
    lat[0] = 1; lat[1] = 1; lat[2] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_rvalid == 1'b0 && t_req == '0, "R9 outputs in reset", 64'({m_rvalid, t_req}), 64'(0));
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_wait == 1'b0 && m_rvalid == 1'b0, "R9 idle after reset", 64'({m_wait, m_rvalid}), 64'(0));
    @(posedge clk); #1;

    // R1: address field decode, including the clamped value
    m_req = 1'b1; m_wren = 1'b1; m_addr = 32'h3000_0010;
    @(negedge clk);
    chk(t_req == 3'b100, "R1 field 3 selects last target", 64'(t_req), 64'h4);
    @(posedge clk); #1;
    m_addr = 32'h1000_0020;
    @(negedge clk);
    chk(t_req == 3'b010, "R1 field 1 selects target 1", 64'(t_req), 64'h2);
    @(posedge clk); #1;
    m_req = 1'b0;

    // R3: selected target's wait is returned
    stall = 3'b010;
    m_req = 1'b1; m_wren = 1'b1; m_addr = 32'h1000_0000;
    @(negedge clk);
    chk(m_wait == 1'b1, "R3 stalled target holds master", 64'(m_wait), 64'h1);
    @(posedge clk); #1;
    m_addr = 32'h0000_0000;
    @(negedge clk);
    chk(m_wait == 1'b0, "R3 other target not stalled", 64'(m_wait), 64'h0);
    @(posedge clk); #1;
    m_req = 1'b0; stall = '0;

    // R6: single read, reply goes straight through
    d0 = bypass_hits;
    xfer(2, 0);
    idle(4);
    chk(bypass_hits > d0, "R6 same-cycle pass-through", 64'(bypass_hits), 64'(d0 + 1));

    // R7: slow first target, fast later ones -> out-of-order arrival
    lat[0] = 8; lat[1] = 3; lat[2] = 1;
    d0 = parked;
    xfer(0, 0); xfer(1, 0); xfer(2, 0);
    idle(15);
    chk(parked >= d0 + 2, "R7 early replies parked", 64'(parked), 64'(d0 + 2));

    // R7: three replies landing in one cycle
    lat[0] = 3; lat[1] = 2; lat[2] = 1;
    xfer(0, 0); xfer(1, 0); xfer(2, 0);
    idle(10);
    chk(max_simul >= 3, "R7 simultaneous replies", 64'(max_simul), 64'(3));

    // R8: writes leave no trace in the reply path
    d0 = delivered;
    xfer(0, 1); xfer(1, 1); xfer(2, 1); xfer(3, 1);
    idle(12);
    chk(delivered == d0 && issue_q.size() == 0, "R8 writes give no reply",
        64'(delivered), 64'(d0));
    xfer(1, 0);
    idle(6);
    chk(delivered == d0 + 1, "R8 next read answered alone", 64'(delivered), 64'(d0 + 1));

    // R4 / R10: fill the order queue
    lat[0] = 40;
    d0 = delivered;
    for (int k = 0; k < QD; k++) xfer(0, 0);
    m_req = 1'b1; m_wren = 1'b0; m_addr = 32'h2000_0000;
    @(negedge clk);
    chk(m_wait == 1'b1 && t_req == '0, "R4 read held when queue full",
        64'({m_wait, t_req}), 64'h8);
    @(posedge clk); #1;
    m_wren = 1'b1;
    @(negedge clk);
    chk(m_wait == 1'b0, "R4 write passes when queue full", 64'(m_wait), 64'h0);
    @(posedge clk); #1;
    m_req = 1'b0;
    xfer(2, 0);
    idle(60);
    chk(delivered == d0 + QD + 1, "R10 every queued read delivered once",
        64'(delivered), 64'(d0 + QD + 1));

    // Mixed random traffic
    lat[0] = 1 + int'($urandom % 6); lat[1] = 1 + int'($urandom % 6); lat[2] = 1;
    lat_var = 4; rand_stall = 1;
    for (int k = 0; k < 400; k++) begin
      xfer(int'($urandom % 4), ($urandom % 4) == 0);
      if ($urandom % 5 == 0) idle(int'($urandom % 3));
    end
    rand_stall = 0;
    idle(1);
    stall = '0;
    idle(60);
    chk(issue_q.size() == 0, "R5 all reads answered in order", 64'(issue_q.size()), 64'(0));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule